// File: doc/BRIEF.md
# Memory March Pattern Test Engine

This block is a self-test sequencer for a synchronous single-port SRAM with one-cycle read latency. After a start pulse it takes over the memory port and runs four phases over every address in ascending order. Each phase first writes and then reads back. The four phases cover stuck-low bits, stuck-high bits, address aliasing and data-pattern sensitivity. The last phase dwells on each word and walks a right-shifting alternating-bit value through it until the value is zero.

While running, the block drives address, write data and write enable, and it compares the returned word against its own expectation. On the first disagreement it halts and keeps a record of the failing location, the expected word and the returned word. Otherwise it finishes cleanly. A two-bit phase output shows progress. The data width and address width are parameters.

Top module: `mem_march_bist`

## Requirements
- R1: After reset, busy, done, fail and mem_we are 0 and phase is 0.
- R2: A start seen while not busy begins the test on the next cycle: busy is 1, phase is 0, and a write to address 0 is on the port. A start seen while busy has no effect on the port sequence.
- R3: Phase 0 writes 0 to addresses 0 up to the last address. It then reads each address in ascending order, holding each read address on the port for two cycles with mem_we low.
- R4: Phase 1 follows the same write-then-read order with every data bit set to 1.
- R5: Phase 2 follows the same order with the data word equal to the address, zero-extended or truncated to the data width.
- R6: Phase 3 first writes the alternating word (bit i set when i is odd, 0xAA for 8 bits) to every address. Then, for each address in turn, it reads and expects that word. After each good read it shifts the current value right by one, writes it and reads it back. When the all-zero word has been read back correctly, it moves to the next address.
- R7: The phase output carries 0, 1, 2 or 3 for the phase in progress, and never moves backwards during a run.
- R8: On the first mismatch the engine stops. It sets fail and done, clears busy, and holds fail_addr, fail_exp and fail_act until the next start. A new start clears fail.
- R9: After a run with no mismatch, done is 1 and fail, busy and mem_we are 0.
- R10: The word returned on mem_rdata in the cycle after a read address is issued is the word compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run when idle or finished |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test ended (pass or fail) |
| fail | output | 1 | A mismatch stopped the test |
| phase | output | 2 | Current phase number |
| fail_addr | output | ADDR_W | Address of the mismatch |
| fail_exp | output | DATA_W | Expected word at the mismatch |
| fail_act | output | DATA_W | Returned word at the mismatch |

## Verification
The hardest case to reach is a mismatch that appears only in one particular phase, because a healthy memory never produces one. The bench memory model therefore carries selectable defects. A stuck read bit makes the run fail in the zero phase. An ignored address bit leaves the solid phases clean and breaks the address-value phase. A corruption triggered by one specific written value appears only while a shifted pattern passes through a word. On a clean memory, every port operation is compared in lockstep against a sequence built in the bench, including a start pulse injected mid-run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RADDR,
        ST_RCMP,
        ST_SHIFT_WR,
        ST_END
    } mbist_state_e;

    localparam logic [1:0] PH_ZERO  = 2'd0;
    localparam logic [1:0] PH_ONES  = 2'd1;
    localparam logic [1:0] PH_ADDR  = 2'd2;
    localparam logic [1:0] PH_SHIFT = 2'd3;

endpackage

// File: rtl/mbist_datagen.sv
module mbist_datagen #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic [1:0]        phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] shift_word,
    output logic [DATA_W-1:0] word
);
    import mbist_pkg::*;

    logic [DATA_W-1:0] addr_word;

    generate
        if (DATA_W > ADDR_W) begin : g_extend
            assign addr_word = {{(DATA_W-ADDR_W){1'b0}}, addr};
        end else if (DATA_W == ADDR_W) begin : g_equal
            assign addr_word = addr;
        end else begin : g_trunc
            assign addr_word = addr[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        case (phase)
            PH_ZERO: word = '0;
            PH_ONES: word = '1;
            PH_ADDR: word = addr_word;
            default: word = shift_word;
        endcase
    end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] want,
    output logic              mismatch
);
    assign mismatch = (got != want);
endmodule

// File: rtl/mem_march_bist.sv
module mem_march_bist #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        phase,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);
    import mbist_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        mbist_state_e      state;
        logic [1:0]        phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] pat;
        logic [DATA_W-1:0] expv;
        logic              fail;
        logic [ADDR_W-1:0] f_addr;
        logic [DATA_W-1:0] f_exp;
        logic [DATA_W-1:0] f_act;
    } regs_t;

    regs_t r_q, r_d;

    // Alternating word: odd bit positions set.
    logic [DATA_W-1:0] alt_word;
    generate
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_alt
            assign alt_word[gi] = (gi % 2 == 1);
        end
    endgenerate

    logic [DATA_W-1:0] gen_word;
    logic              mismatch;

    mbist_datagen #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) datagen_i (
        .phase      (r_q.phase),
        .addr       (r_q.addr),
        .shift_word (r_q.pat),
        .word       (gen_word)
    );

    mbist_cmp #(
        .DATA_W(DATA_W)
    ) cmp_i (
        .got      (mem_rdata),
        .want     (r_q.expv),
        .mismatch (mismatch)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE, ST_END: begin
                if (start) begin
                    r_d.state = ST_FILL;
                    r_d.phase = PH_ZERO;
                    r_d.addr  = '0;
                    r_d.pat   = alt_word;
                    r_d.fail  = 1'b0;
                end
            end
            ST_FILL: begin
                if (r_q.addr == LAST_ADDR) begin
                    r_d.addr  = '0;
                    r_d.state = ST_RADDR;
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                end
            end
            ST_RADDR: begin
                r_d.expv  = gen_word;
                r_d.state = ST_RCMP;
            end
            ST_RCMP: begin
                if (mismatch) begin
                    r_d.fail   = 1'b1;
                    r_d.f_addr = r_q.addr;
                    r_d.f_exp  = r_q.expv;
                    r_d.f_act  = mem_rdata;
                    r_d.state  = ST_END;
                end else if (r_q.phase != PH_SHIFT) begin
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.phase = r_q.phase + 2'd1;
                        r_d.addr  = '0;
                        r_d.pat   = alt_word;
                        r_d.state = ST_FILL;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = ST_RADDR;
                    end
                end else if (r_q.pat == '0) begin
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.state = ST_END;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.pat   = alt_word;
                        r_d.state = ST_RADDR;
                    end
                end else begin
                    r_d.pat   = r_q.pat >> 1;
                    r_d.state = ST_SHIFT_WR;
                end
            end
            ST_SHIFT_WR: begin
                r_d.state = ST_RADDR;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.phase  <= PH_ZERO;
            r_q.addr   <= '0;
            r_q.pat    <= '0;
            r_q.expv   <= '0;
            r_q.fail   <= 1'b0;
            r_q.f_addr <= '0;
            r_q.f_exp  <= '0;
            r_q.f_act  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_wdata = gen_word;
    assign mem_we    = (r_q.state == ST_FILL) || (r_q.state == ST_SHIFT_WR);
    assign busy      = (r_q.state != ST_IDLE) && (r_q.state != ST_END);
    assign done      = (r_q.state == ST_END);
    assign fail      = r_q.fail;
    assign phase     = r_q.phase;
    assign fail_addr = r_q.f_addr;
    assign fail_exp  = r_q.f_exp;
    assign fail_act  = r_q.f_act;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_exp,
    input logic [DATA_W-1:0] fail_act
);
    p_we_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_end_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_we));

    p_fail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !fail && phase == 2'd0 && mem_we && mem_addr == '0));

    p_phase_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (phase == $past(phase) || phase == $past(phase) + 2'd1));
endmodule

bind mem_march_bist mbist_march_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .phase     (phase),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
);

// File: tb/mem_march_bist_tb_top.sv
`timescale 1ns/1ps
module mem_march_bist_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [1:0]    phase;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_act;

    int tests = 0;
    int errors = 0;
    int op_idx = 0;
    int fault_sel = 0;

    always #2.5 clk = ~clk;

    mem_march_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .phase(phase), .fail_addr(fail_addr), .fail_exp(fail_exp),
        .fail_act(fail_act)
    );

    // Memory model with selectable defects:
    // 1 = bit 0 of address 5 reads as 1; 2 = address bit 3 ignored;
    // 3 = writing 0x15 stores 0x14.
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] eff_addr;
    always_comb eff_addr = (fault_sel == 2) ? (mem_addr & 4'h7) : mem_addr;

    initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'h3C;

    always @(posedge clk) begin
        if (mem_we)
            mem[eff_addr] <= (fault_sel == 3 && mem_wdata == 8'h15) ? 8'h14 : mem_wdata;
        mem_rdata <= mem[eff_addr] | ((fault_sel == 1 && eff_addr == 4'd5) ? 8'h01 : 8'h00);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // One port operation in lockstep; a stray start is pulsed at op 40.
    task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] ph, input string req);
        bit ok;
        @(negedge clk);
        ok = (mem_we === we) && (mem_addr === a) && (phase === ph) && busy === 1'b1
             && fail === 1'b0 && (!we || mem_wdata === d);
        check(ok, req, $sformatf("op%0d we/addr/data/phase", op_idx),
              {mem_we, 3'b0, mem_addr, mem_wdata, 6'b0, phase, 8'b0},
              {we, 3'b0, a, d, 6'b0, ph, 8'b0});
        op_idx++;
        start = (op_idx == 40);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [1:0] ph, input string req);
        op(1'b0, a, '0, ph, req);
        op(1'b0, a, '0, ph, req);
    endtask

    task automatic run_clean();
        logic [DW-1:0] p;
        op_idx = 0;
        @(negedge clk);
        start = 1'b1;
        for (int ph = 0; ph < 3; ph++) begin
            for (int a = 0; a < DEPTH; a++)
                op(1'b1, a[AW-1:0], (ph == 0) ? 8'h00 : (ph == 1) ? 8'hFF : 8'(a), ph[1:0],
                   (ph == 0) ? "R3" : (ph == 1) ? "R4" : "R5");
            for (int a = 0; a < DEPTH; a++)
                rd(a[AW-1:0], ph[1:0], "R10");
        end
        for (int a = 0; a < DEPTH; a++) op(1'b1, a[AW-1:0], 8'hAA, 2'd3, "R6");
        for (int a = 0; a < DEPTH; a++) begin
            rd(a[AW-1:0], 2'd3, "R6");
            p = 8'hAA;
            while (p != 0) begin
                p = p >> 1;
                op(1'b1, a[AW-1:0], p, 2'd3, "R6");
                rd(a[AW-1:0], 2'd3, "R6");
            end
        end
        @(negedge clk);
        check(done === 1'b1 && fail === 1'b0 && busy === 1'b0 && mem_we === 1'b0,
              "R9", "end flags d/f/b/we", {done, fail, busy, mem_we}, 4'b1000);
    endtask

    task automatic run_fault(input int sel, input logic [AW-1:0] ea, input logic [DW-1:0] ee,
                             input logic [DW-1:0] eact, input logic [1:0] eph);
        int n;
        fault_sel = sel;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(fail === 1'b0 && busy === 1'b1, "R8", "fail cleared by start",
              {fail, busy}, 2'b01);
        n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1 && fail === 1'b1 && busy === 1'b0, "R8", "stop flags",
              {done, fail, busy}, 3'b110);
        check(fail_addr === ea, "R8", "fail_addr", fail_addr, ea);
        check(fail_exp === ee, "R8", "fail_exp", fail_exp, ee);
        check(fail_act === eact, "R8", "fail_act", fail_act, eact);
        check(phase === eph, "R7", "phase at stop", phase, eph);
        repeat (5) @(negedge clk);
        check(fail === 1'b1 && fail_addr === ea && fail_act === eact && mem_we === 1'b0,
              "R8", "record held", {fail, fail_addr, fail_act}, {1'b1, ea, eact});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && fail === 1'b0 && mem_we === 1'b0 && phase === 2'd0,
              "R1", "reset outputs", {busy, done, fail, mem_we, phase}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", {busy, done}, 2'b00);
        run_clean();                                // R2 stray start at op 40 ignored
        run_fault(1, 4'd5, 8'h00, 8'h01, 2'd0);     // stuck bit in zero phase
        run_fault(2, 4'd0, 8'h00, 8'h08, 2'd2);     // aliasing caught by address phase
        run_fault(3, 4'd0, 8'h15, 8'h14, 2'd3);     // pattern-sensitive corruption
        fault_sel = 0;
        run_clean();                                // R8 restart after fail, clean pass
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end
endmodule